// File: doc/BRIEF.md
# DMA Address and Word-Count Counter Pair

This block holds the two counting registers of a DMA-style peripheral interface. One is a bus address counter and the other is a transfer word counter. Each is 16 bits wide and is loaded one byte at a time from a shared data input. Each advances by one or by two when a pulse on its count input ends. Each raises a one-cycle overflow flag when its count wraps past all ones.

The address counter is split after bit 3. Its upper twelve bits take the low nibble's carry only while an external carry-in is asserted. With the carry-in tied active, the counter runs through the full 16-bit range. With it held inactive, the address sweeps the same 16-byte window over and over, which suits device-to-device moves.

Three output enables select what appears on the outputs. The word count or the address can be placed on the data-bus output, and the address can be placed on the address-bus output. A disabled output reads as zero. All logic runs on one clock, with an active-low asynchronous reset.

Top module: `dma_addr_wc_regs`

## Requirements
- R1: While rst_ni is low, and after it is released, both counters, both overflow flags and both bus outputs are zero.
- R2: Loads are byte-selective. A low-byte strobe writes data_i[7:0] into bits 7:0 and a high-byte strobe writes data_i[15:8] into bits 15:8 of its own counter. The other byte is left unchanged, and the result is visible one clock later.
- R3: A counter's step is +1 while its step-select input is 1 and +2 while it is 0.
- R4: A counter advances once per count pulse, in the clock after its count input is sampled high and then low. A count input held high or held low causes no change.
- R5: With ba_carry_in_i low, address bits 15:4 never change on a count, while bits 3:0 wrap modulo 16. With ba_carry_in_i high, the address counts over the full 16 bits.
- R6: When a count carries out of bit 15 (for example 0xFFFF+1 or 0xFFFE+2 with full carry), the counter's overflow flag is high for exactly the one cycle in which the wrapped value first appears. It is low otherwise.
- R7: clear_i resets both counters and both overflow flags to zero on the next clock. It takes priority over loads and counts in the same cycle.
- R8: If a byte load and a count edge reach the same counter in the same cycle, the load is applied and that count is discarded.
- R9: dbus_o shows the word count when wc_to_dbus_i is 1. Otherwise it shows the address when ba_to_dbus_i is 1, and otherwise it is zero. abus_o shows the address when ba_to_abus_i is 1 and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of both counters |
| data_i | input | 16 | Load data |
| ld_wc_lo_i | input | 1 | Load word-count bits 7:0 |
| ld_wc_hi_i | input | 1 | Load word-count bits 15:8 |
| ld_ba_lo_i | input | 1 | Load address bits 7:0 |
| ld_ba_hi_i | input | 1 | Load address bits 15:8 |
| cnt_wc_i | input | 1 | Word-count pulse; its falling edge steps the counter |
| cnt_ba_i | input | 1 | Address pulse; its falling edge steps the counter |
| wc_step1_i | input | 1 | Word-count step select: 1 gives +1, 0 gives +2 |
| ba_step1_i | input | 1 | Address step select: 1 gives +1, 0 gives +2 |
| ba_carry_in_i | input | 1 | Lets the low-nibble carry reach address bits 15:4 |
| wc_to_dbus_i | input | 1 | Place word count on dbus_o |
| ba_to_dbus_i | input | 1 | Place address on dbus_o |
| ba_to_abus_i | input | 1 | Place address on abus_o |
| dbus_o | output | 16 | Data-bus output |
| abus_o | output | 16 | Address-bus output |
| wc_ovf_o | output | 1 | Word-count overflow pulse |
| ba_ovf_o | output | 1 | Address overflow pulse |

## Verification
Two pairs of functions can collide in one cycle. A byte load can meet a count edge, and a clear can meet both a load and a count edge. The bench provokes each collision by releasing a count pulse in the same cycle as a load strobe, and then in the same cycle as clear with load strobes also raised. A reference model that applies clear, then load, then count judges the result, and it is compared with both bus outputs and both overflow flags on every clock.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int unsigned DMA_W     = 16;
  localparam int unsigned DMA_WIN_W = 4;
  localparam int unsigned BYTE_W    = 8;
endpackage

// File: rtl/fall_det.sv
module fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;

  assign fall_o = lvl_q & ~lvl_i;

  // R4: a pulse yields one edge only
  a_r4_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/step_counter.sv
module step_counter #(
  parameter int unsigned W     = dma_regs_pkg::DMA_W,
  parameter int unsigned LOW_W = dma_regs_pkg::DMA_WIN_W,
  parameter bit          SPLIT = 1'b0,
  localparam int unsigned NB   = W / dma_regs_pkg::BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [NB-1:0] ld_i,
  input  logic [W-1:0]  data_i,
  input  logic          inc_i,
  input  logic          step1_i,
  input  logic          carry_in_i,
  output logic [W-1:0]  q_o,
  output logic          ovf_o
);
  localparam int unsigned BW = dma_regs_pkg::BYTE_W;

  logic [W-1:0] q_q, nxt;
  logic         wrap, ovf_q;
  logic [W-1:0] step;

  assign step = step1_i ? W'(1) : W'(2);

  if (SPLIT) begin : g_split
    localparam int unsigned UP_W = W - LOW_W;
    logic [LOW_W:0] low_sum;
    logic [UP_W:0]  up_sum;
    logic           adv;
    assign low_sum = {1'b0, q_q[LOW_W-1:0]} + step[LOW_W:0];
    assign adv     = low_sum[LOW_W] & carry_in_i;
    assign up_sum  = {1'b0, q_q[W-1:LOW_W]} + {{UP_W{1'b0}}, adv};
    assign nxt     = {up_sum[UP_W-1:0], low_sum[LOW_W-1:0]};
    assign wrap    = up_sum[UP_W];

    // R5: upper part frozen while carry-in is inhibited
    a_r5_upper_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && ld_i == '0 && !carry_in_i) |=> $stable(q_o[W-1:LOW_W]));
  end else begin : g_full
    logic [W:0] sum;
    assign sum  = {1'b0, q_q} + {1'b0, step};
    assign nxt  = sum[W-1:0];
    assign wrap = sum[W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      q_q   <= '0;
      ovf_q <= 1'b0;
    end else if (ld_i != '0) begin
      for (int b = 0; b < NB; b++)
        if (ld_i[b]) q_q[b*BW +: BW] <= data_i[b*BW +: BW];
      ovf_q <= 1'b0;
    end else if (inc_i) begin
      q_q   <= nxt;
      ovf_q <= wrap;
    end else begin
      ovf_q <= 1'b0;
    end
  end

  assign q_o   = q_q;
  assign ovf_o = ovf_q;

  // R6: overflow lasts one cycle
  a_r6_ovf_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);
  // R4: no change without a count edge
  a_r4_hold_no_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && ld_i == '0 && !inc_i) |=> $stable(q_o));
  // R7: clear wins
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (q_o == '0 && !ovf_o));
endmodule

// File: rtl/dma_addr_wc_regs.sv
module dma_addr_wc_regs
  import dma_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [DMA_W-1:0] data_i,
  input  logic             ld_wc_lo_i,
  input  logic             ld_wc_hi_i,
  input  logic             ld_ba_lo_i,
  input  logic             ld_ba_hi_i,
  input  logic             cnt_wc_i,
  input  logic             cnt_ba_i,
  input  logic             wc_step1_i,
  input  logic             ba_step1_i,
  input  logic             ba_carry_in_i,
  input  logic             wc_to_dbus_i,
  input  logic             ba_to_dbus_i,
  input  logic             ba_to_abus_i,
  output logic [DMA_W-1:0] dbus_o,
  output logic [DMA_W-1:0] abus_o,
  output logic             wc_ovf_o,
  output logic             ba_ovf_o
);
  logic             wc_fall, ba_fall;
  logic [DMA_W-1:0] wc_q, ba_q;

  fall_det i_wc_edge (.clk_i, .rst_ni, .lvl_i(cnt_wc_i), .fall_o(wc_fall));
  fall_det i_ba_edge (.clk_i, .rst_ni, .lvl_i(cnt_ba_i), .fall_o(ba_fall));

  step_counter #(.W(DMA_W), .LOW_W(DMA_WIN_W), .SPLIT(1'b0)) i_wc_cnt (
    .clk_i, .rst_ni, .clr_i(clear_i), .ld_i({ld_wc_hi_i, ld_wc_lo_i}),
    .data_i, .inc_i(wc_fall), .step1_i(wc_step1_i), .carry_in_i(1'b1),
    .q_o(wc_q), .ovf_o(wc_ovf_o));

  step_counter #(.W(DMA_W), .LOW_W(DMA_WIN_W), .SPLIT(1'b1)) i_ba_cnt (
    .clk_i, .rst_ni, .clr_i(clear_i), .ld_i({ld_ba_hi_i, ld_ba_lo_i}),
    .data_i, .inc_i(ba_fall), .step1_i(ba_step1_i), .carry_in_i(ba_carry_in_i),
    .q_o(ba_q), .ovf_o(ba_ovf_o));

  always_comb begin
    if (wc_to_dbus_i)      dbus_o = wc_q;
    else if (ba_to_dbus_i) dbus_o = ba_q;
    else                   dbus_o = '0;
  end

  assign abus_o = ba_to_abus_i ? ba_q : '0;

  // R9: disabled gates read as zero
  a_r9_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ba_to_abus_i |-> abus_o == '0) and
    ((!wc_to_dbus_i && !ba_to_dbus_i) |-> dbus_o == '0));
endmodule

// File: tb/test_dma_addr_wc_regs.sv
module test_dma_addr_wc_regs;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic clear = 0, ld_wc_lo = 0, ld_wc_hi = 0, ld_ba_lo = 0, ld_ba_hi = 0;
  logic cnt_wc = 0, cnt_ba = 0, wc_step1 = 1, ba_step1 = 1, ba_cin = 1;
  logic wc_db = 1, ba_db = 0, ba_ab = 1;
  logic [15:0] data = 0;
  logic [15:0] dbus, abus;
  logic wc_ovf, ba_ovf;

  int errors = 0, checks = 0, cycles = 0;
  string cur_req = "R1";
  int m_wc = 0, m_ba = 0, m_wovf = 0, m_bovf = 0, p_wc = 0, p_ba = 0;

  always #4 clk = ~clk;

  dma_addr_wc_regs i_dma_addr_wc_regs (
    .clk_i(clk), .rst_ni, .clear_i(clear), .data_i(data),
    .ld_wc_lo_i(ld_wc_lo), .ld_wc_hi_i(ld_wc_hi), .ld_ba_lo_i(ld_ba_lo), .ld_ba_hi_i(ld_ba_hi),
    .cnt_wc_i(cnt_wc), .cnt_ba_i(cnt_ba), .wc_step1_i(wc_step1), .ba_step1_i(ba_step1),
    .ba_carry_in_i(ba_cin), .wc_to_dbus_i(wc_db), .ba_to_dbus_i(ba_db), .ba_to_abus_i(ba_ab),
    .dbus_o(dbus), .abus_o(abus), .wc_ovf_o(wc_ovf), .ba_ovf_o(ba_ovf));

  // behavioural reference: clear, then load, then count
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_wc = 0; m_ba = 0; m_wovf = 0; m_bovf = 0; p_wc = 0; p_ba = 0;
    end else begin
      bit fw, fb;
      fw = (p_wc == 1) && !cnt_wc;
      fb = (p_ba == 1) && !cnt_ba;
      p_wc = cnt_wc; p_ba = cnt_ba;
      if (clear) begin
        m_wc = 0; m_ba = 0; m_wovf = 0; m_bovf = 0;
      end else begin
        if (ld_wc_lo || ld_wc_hi) begin
          if (ld_wc_lo) m_wc = (m_wc & 'hFF00) | (data & 'hFF);
          if (ld_wc_hi) m_wc = (m_wc & 'h00FF) | (data & 'hFF00);
          m_wovf = 0;
        end else if (fw) begin
          int t;
          t = m_wc + (wc_step1 ? 1 : 2);
          m_wovf = (t > 65535);
          m_wc = t % 65536;
        end else m_wovf = 0;
        if (ld_ba_lo || ld_ba_hi) begin
          if (ld_ba_lo) m_ba = (m_ba & 'hFF00) | (data & 'hFF);
          if (ld_ba_hi) m_ba = (m_ba & 'h00FF) | (data & 'hFF00);
          m_bovf = 0;
        end else if (fb) begin
          int lo, up;
          lo = (m_ba % 16) + (ba_step1 ? 1 : 2);
          up = m_ba / 16;
          if (lo >= 16 && ba_cin) up = up + 1;
          m_bovf = (up >= 4096);
          m_ba = (up % 4096) * 16 + (lo % 16);
        end else m_bovf = 0;
      end
    end
    #2 compare();
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare();
    int e_d, e_a;
    e_d = wc_db ? m_wc : (ba_db ? m_ba : 0);
    e_a = ba_ab ? m_ba : 0;
    chk("dbus", int'(dbus), e_d);
    chk("abus", int'(abus), e_a);
    chk("wc_ovf", int'(wc_ovf), m_wovf);
    chk("ba_ovf", int'(ba_ovf), m_bovf);
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_both();
    cnt_wc = 1; cnt_ba = 1; tick();
    cnt_wc = 0; cnt_ba = 0; tick(2);
  endtask

  task automatic load_wc(input logic [15:0] v);
    data = v; ld_wc_lo = 1; ld_wc_hi = 1; tick(); ld_wc_lo = 0; ld_wc_hi = 0;
  endtask

  task automatic load_ba(input logic [15:0] v);
    data = v; ld_ba_lo = 1; ld_ba_hi = 1; tick(); ld_ba_lo = 0; ld_ba_hi = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    tick(3); rst_ni = 1; tick(2);
    // R2: byte loads
    cur_req = "R2";
    data = 16'h1234; ld_wc_lo = 1; tick(); ld_wc_lo = 0;
    data = 16'hAB00; ld_wc_hi = 1; tick(); ld_wc_hi = 0;
    data = 16'h00CD; ld_ba_lo = 1; tick(); ld_ba_lo = 0;
    data = 16'h5600; ld_ba_hi = 1; tick(); ld_ba_hi = 0; tick();
    // R3: step sizes
    cur_req = "R3";
    load_wc(16'h0100); load_ba(16'h2000);
    pulse_both(); pulse_both();
    wc_step1 = 0; ba_step1 = 0;
    pulse_both(); pulse_both();
    wc_step1 = 1; ba_step1 = 1;
    // R4: held levels do not count
    cur_req = "R4";
    cnt_wc = 1; cnt_ba = 1; tick(5);
    cnt_wc = 0; cnt_ba = 0; tick(5);
    // R5: carry-in gating of upper address bits
    cur_req = "R5";
    load_ba(16'h123E); ba_cin = 0; ba_step1 = 0;
    for (int i = 0; i < 10; i++) pulse_both();
    ba_step1 = 1;
    for (int i = 0; i < 20; i++) pulse_both();
    ba_cin = 1; load_ba(16'h123E); ba_step1 = 0;
    pulse_both(); ba_step1 = 1;
    load_ba(16'hFFFF); ba_cin = 0; pulse_both(); ba_cin = 1;
    // R6: overflow pulses
    cur_req = "R6";
    load_wc(16'hFFFF); load_ba(16'hFFFE); ba_step1 = 0;
    pulse_both();
    wc_step1 = 0; load_wc(16'hFFFF); load_ba(16'hFFFF);
    pulse_both();
    wc_step1 = 1; ba_step1 = 1;
    // R8: load beats count in the same cycle
    cur_req = "R8";
    load_wc(16'h0010); load_ba(16'h0020);
    cnt_wc = 1; cnt_ba = 1; tick();
    cnt_wc = 0; cnt_ba = 0; data = 16'h7788; ld_wc_lo = 1; ld_ba_hi = 1; tick();
    ld_wc_lo = 0; ld_ba_hi = 0; tick(2);
    pulse_both();
    // R7: clear over load and count
    cur_req = "R7";
    cnt_wc = 1; cnt_ba = 1; tick();
    cnt_wc = 0; cnt_ba = 0; clear = 1; data = 16'hFFFF;
    ld_wc_lo = 1; ld_wc_hi = 1; ld_ba_lo = 1; ld_ba_hi = 1; tick();
    clear = 0; ld_wc_lo = 0; ld_wc_hi = 0; ld_ba_lo = 0; ld_ba_hi = 0; tick(2);
    // R9: output gating and priority
    cur_req = "R9";
    load_wc(16'hA5A5); load_ba(16'h5A5A);
    wc_db = 0; ba_db = 0; ba_ab = 0; tick(2);
    ba_db = 1; tick(2);
    wc_db = 1; tick(2);
    ba_ab = 1; wc_db = 0; tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule